// File: doc/BRIEF.md
# Prioritized Address-Region Access Checker

This block screens the accesses of one bus master against a small set of programmable address regions. Each region has an inclusive lower and upper bound, an enable, and separate read and write grants. When several enabled regions cover the same address, the region with the highest number decides the outcome. A narrow high-numbered region can therefore open a write window inside a broad low-numbered region that only grants reads. Any address that no enabled region covers is refused.

Accesses arrive on a valid/ready request channel. The verdict leaves on a valid/ready response channel one cycle after the request is accepted. The response holds allow, deny and the number of the deciding region. The first refused access is also latched into an error record (address, direction, region) that stays put until `err_clear` is pulsed. The region configuration is plain input pins, and the block only reads them.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in that same cycle (`resp_ready` high). While `resp_valid` is high and `resp_ready` is low, the response stays frozen and no new request is taken.

Top module: `region_access_guard`

## Requirements
- R1: A region covers an address only when its enable bit is set and lo <= addr <= hi, with both bounds included.
- R2: When several enabled regions cover the address, the one with the highest number decides. Regions are numbered 1..NREG, region k is configured in slice k-1 of each flat config bus, and `resp_region` reports the deciding region's number.
- R3: An access is allowed only if the deciding region grants its direction: `req_write`=1 needs the region's write bit, and `req_write`=0 needs its read bit.
- R4: An access that no enabled region covers is denied and reports `resp_region` = 0.
- R5: While `resp_valid` is high, exactly one of `resp_allow` and `resp_deny` is high. While it is low, both are low.
- R6: `req_ready` is high when `resp_valid` is low or `resp_ready` is high. A stalled response keeps its values, and no request is taken during the stall.
- R7: The verdict for a request taken on one rising edge is presented on the next edge, with `resp_valid` high.
- R8: The first denied access after reset or clear sets `err_valid` and records its address, its direction (1 = write) and its region number. Later denials leave the record unchanged while `err_valid` is high.
- R9: `err_clear` empties the error record on the next edge. It wins over a denial taken on that same edge, which is then not recorded.
- R10: After reset, `resp_valid` and `err_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_lo | input | NREG*AW | Per-region inclusive lower bounds |
| cfg_hi | input | NREG*AW | Per-region inclusive upper bounds |
| cfg_en | input | NREG | Per-region enable |
| cfg_rd | input | NREG | Per-region read grant |
| cfg_wr | input | NREG | Per-region write grant |
| resp_valid | output | 1 | Verdict present |
| resp_ready | input | 1 | Consumer takes the verdict |
| resp_allow | output | 1 | Access permitted |
| resp_deny | output | 1 | Access refused |
| resp_region | output | IDXW | Deciding region number, 0 if none |
| err_clear | input | 1 | Empty the error record |
| err_valid | output | 1 | Error record holds a denial |
| err_addr | output | AW | Address of the recorded denial |
| err_write | output | 1 | Direction of the recorded denial |
| err_region | output | IDXW | Region of the recorded denial |

## Verification
The hardest situations to reach from the ports are the ones where two effects coincide on one edge: a new denial while an older one is already recorded, a clear pulse on the very edge a denial is taken, and a request offered while the response is stalled. The stimulus reaches them on purpose. A table of accesses against overlapping regions produces several denials in a row. A denial is then issued with `err_clear` held high. Finally `resp_ready` is held low while a second, different request is presented, and the bench checks that the frozen verdict and the untouched error record are what it sees.

// File: rtl/rag_pkg.sv
package rag_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned REGIONS = 3;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;
endpackage

// File: rtl/rag_region_cmp.sv
module rag_region_cmp #(
  parameter int unsigned AW = rag_pkg::ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    hit      = en && above_lo && below_hi;
  end
endmodule

// File: rtl/rag_prio_pick.sv
module rag_prio_pick #(
  parameter int unsigned N    = rag_pkg::REGIONS,
  parameter int unsigned IDXW = $clog2(N + 1)
) (
  input  logic [N-1:0]    hit,
  input  logic [N-1:0]    rd_ok,
  input  logic [N-1:0]    wr_ok,
  output logic            any,
  output logic [IDXW-1:0] win,
  output logic            win_rd,
  output logic            win_wr
);
  always_comb begin
    any    = 1'b0;
    win    = '0;
    win_rd = 1'b0;
    win_wr = 1'b0;
    // ascending scan: a later (higher) match overwrites an earlier one
    for (int i = 0; i < int'(N); i++) begin
      if (hit[i]) begin
        any    = 1'b1;
        win    = IDXW'(i + 1);
        win_rd = rd_ok[i];
        win_wr = wr_ok[i];
      end
    end
  end
endmodule

// File: rtl/rag_err_latch.sv
module rag_err_latch #(
  parameter int unsigned AW   = rag_pkg::ADDR_W,
  parameter int unsigned IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            clear,
  input  logic [AW-1:0]   addr,
  input  logic            write,
  input  logic [IDXW-1:0] region,
  output logic            err_valid,
  output logic [AW-1:0]   err_addr,
  output logic            err_write,
  output logic [IDXW-1:0] err_region
);
  import rag_pkg::*;
  dir_e dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid  <= 1'b0;
      err_addr   <= '0;
      dir_q      <= DIR_READ;
      err_region <= '0;
    end else if (clear) begin
      err_valid <= 1'b0;
    end else if (capture && !err_valid) begin
      err_valid  <= 1'b1;
      err_addr   <= addr;
      dir_q      <= write ? DIR_WRITE : DIR_READ;
      err_region <= region;
    end
  end

  assign err_write = (dir_q == DIR_WRITE);

  // R8: a held record is not overwritten by later denials
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !clear |=> err_valid && $stable(err_addr) && $stable(err_region)
                            && $stable(err_write));
  // R9: clear empties the record on the next edge
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !err_valid);
endmodule

// File: rtl/region_access_guard.sv
module region_access_guard #(
  parameter int unsigned AW   = rag_pkg::ADDR_W,
  parameter int unsigned NREG = rag_pkg::REGIONS,
  parameter int unsigned IDXW = $clog2(NREG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_write,
  input  logic [NREG*AW-1:0]   cfg_lo,
  input  logic [NREG*AW-1:0]   cfg_hi,
  input  logic [NREG-1:0]      cfg_en,
  input  logic [NREG-1:0]      cfg_rd,
  input  logic [NREG-1:0]      cfg_wr,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic                 resp_allow,
  output logic                 resp_deny,
  output logic [IDXW-1:0]      resp_region,
  input  logic                 err_clear,
  output logic                 err_valid,
  output logic [AW-1:0]        err_addr,
  output logic                 err_write,
  output logic [IDXW-1:0]      err_region
);
  logic [NREG-1:0] hit;
  logic            any_hit, sel_rd, sel_wr;
  logic [IDXW-1:0] win;
  logic            grant, take;

  for (genvar g = 0; g < int'(NREG); g++) begin : g_cmp
    rag_region_cmp #(.AW(AW)) u_cmp (
      .addr (req_addr),
      .lo   (cfg_lo[g*AW +: AW]),
      .hi   (cfg_hi[g*AW +: AW]),
      .en   (cfg_en[g]),
      .hit  (hit[g])
    );
  end

  rag_prio_pick #(.N(NREG), .IDXW(IDXW)) u_pick (
    .hit    (hit),
    .rd_ok  (cfg_rd),
    .wr_ok  (cfg_wr),
    .any    (any_hit),
    .win    (win),
    .win_rd (sel_rd),
    .win_wr (sel_wr)
  );

  always_comb begin
    grant     = any_hit && (req_write ? sel_wr : sel_rd);
    req_ready = !resp_valid || resp_ready;
    take      = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_allow  <= 1'b0;
      resp_deny   <= 1'b0;
      resp_region <= '0;
    end else if (take) begin
      resp_valid  <= 1'b1;
      resp_allow  <= grant;
      resp_deny   <= !grant;
      resp_region <= win;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_deny  <= 1'b0;
    end
  end

  rag_err_latch #(.AW(AW), .IDXW(IDXW)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (take && !grant),
    .clear      (err_clear),
    .addr       (req_addr),
    .write      (req_write),
    .region     (win),
    .err_valid  (err_valid),
    .err_addr   (err_addr),
    .err_write  (err_write),
    .err_region (err_region)
  );

  // R7: accepted request yields a verdict on the next edge
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);
  // R6: stalled response is frozen
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_allow)
                                  && $stable(resp_region));
  // R5: allow and deny are mutually exclusive and tied to valid
  a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == (resp_allow ^ resp_deny) && !(resp_allow && resp_deny));
  // R4: no region, no grant
  a_r4_unmatched_denied: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_region == '0 |-> resp_deny);
  // R2: reported region number stays within range
  a_r2_region_range: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_region <= IDXW'(NREG));
endmodule

// File: tb/tb_region_access_guard.sv
module tb_region_access_guard;
  localparam int AW = 32;
  localparam int NREG = 3;
  localparam int IDXW = 2;
  localparam int NV = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1, err_clear = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NREG*AW-1:0] cfg_lo, cfg_hi;
  logic [NREG-1:0] cfg_en, cfg_rd, cfg_wr;
  logic req_ready, resp_valid, resp_allow, resp_deny, err_valid, err_write;
  logic [IDXW-1:0] resp_region, err_region;
  logic [AW-1:0] err_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  region_access_guard dut (.*);

  // {addr, write, expect_allow, expect_region}
  localparam logic [AW+3:0] VEC [NV] = '{
    {32'h0800_0000, 1'b1, 1'b1, 2'd2},
    {32'h0800_27FF, 1'b1, 1'b1, 2'd2},
    {32'h0800_2800, 1'b1, 1'b0, 2'd1},
    {32'h0800_2800, 1'b0, 1'b1, 2'd1},
    {32'h0843_D7FF, 1'b1, 1'b0, 2'd1},
    {32'h0843_D800, 1'b1, 1'b1, 2'd3},
    {32'h0843_FFFF, 1'b1, 1'b1, 2'd3},
    {32'h0844_0000, 1'b0, 1'b0, 2'd0},
    {32'h07FF_FFFF, 1'b0, 1'b0, 2'd0},
    {32'h0820_0000, 1'b0, 1'b1, 2'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_region(input int k, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                            input logic en, input logic rd, input logic wr);
    cfg_lo[(k-1)*AW +: AW] = lo;
    cfg_hi[(k-1)*AW +: AW] = hi;
    cfg_en[k-1] = en;
    cfg_rd[k-1] = rd;
    cfg_wr[k-1] = wr;
  endtask

  // drive at a falling edge, taken at the rising edge, checked at the next falling edge
  task automatic access(input logic [AW-1:0] a, input logic w);
    @(negedge clk);
    req_addr = a; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic verdict(input string req, input logic al, input logic [IDXW-1:0] rg);
    chk({req, " valid"}, resp_valid, 1'b1);
    chk({req, " allow"}, resp_allow, al);
    chk({req, " deny"}, resp_deny, !al);
    chk({req, " region"}, resp_region, rg);
  endtask

  initial begin
    cfg_lo = '0; cfg_hi = '0; cfg_en = '0; cfg_rd = '0; cfg_wr = '0;
    set_region(1, 32'h0800_0000, 32'h0843_FFFF, 1'b1, 1'b1, 1'b0);
    set_region(2, 32'h0800_0000, 32'h0800_27FF, 1'b1, 1'b1, 1'b1);
    set_region(3, 32'h0843_D800, 32'h0843_FFFF, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 resp_valid", resp_valid, 1'b0);
    chk("R10 err_valid", err_valid, 1'b0);
    chk("R10 req_ready", req_ready, 1'b1);

    // table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][AW+3:4], VEC[i][3]);
      verdict($sformatf("R2/R3/R7 vec%0d", i), VEC[i][2], VEC[i][1:0]);
    end
    @(negedge clk);
    chk("R5 idle allow", resp_allow, 1'b0);
    chk("R5 idle deny", resp_deny, 1'b0);
    // R8 first denial kept (vec2: 0x0800_2800 write, region 1)
    chk("R8 err_valid", err_valid, 1'b1);
    chk("R8 err_addr", err_addr, 32'h0800_2800);
    chk("R8 err_write", err_write, 1'b1);
    chk("R8 err_region", err_region, 2'd1);

    // R9 clear, then clear colliding with a denial
    err_clear = 1'b1;
    @(negedge clk);
    chk("R9 cleared", err_valid, 1'b0);
    req_addr = 32'h0900_0000; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; err_clear = 1'b0;
    chk("R9 clear beats denial", err_valid, 1'b0);
    verdict("R4 collide verdict", 1'b0, 2'd0);
    access(32'h0844_0000, 1'b0);
    chk("R8 new err_addr", err_addr, 32'h0844_0000);
    chk("R8 new err_write", err_write, 1'b0);
    chk("R8 new err_region", err_region, 2'd0);

    // R1 disabled region no longer covers
    set_region(3, 32'h0843_D800, 32'h0843_FFFF, 1'b0, 1'b1, 1'b1);
    access(32'h0843_D800, 1'b1);
    verdict("R1 disabled region", 1'b0, 2'd1);

    // peripheral frame in region 1, RAM middle uncovered
    set_region(1, 32'hFFF8_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    access(32'hFFF8_0000, 1'b1);
    verdict("R3 frame write", 1'b1, 2'd1);
    access(32'hFFFF_FFFF, 1'b0);
    verdict("R1 frame top", 1'b1, 2'd1);
    access(32'h0820_0000, 1'b0);
    verdict("R4 uncovered", 1'b0, 2'd0);

    // R6 back-pressure
    resp_ready = 1'b0;
    access(32'h0820_0004, 1'b1);
    verdict("R6 stalled first", 1'b0, 2'd0);
    chk("R6 ready low", req_ready, 1'b0);
    req_addr = 32'h0800_0010; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    verdict("R6 held", 1'b0, 2'd0);
    chk("R8 untouched by stall", err_addr, 32'h0844_0000);
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R5 drained valid", resp_valid, 1'b0);
    chk("R5 drained deny", resp_deny, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule